// File: doc/BRIEF.md
# Byte-Lane EDO DRAM Access Controller

This block converts single-word read and write requests into the strobe sequence of a 256K x 16 asynchronous EDO DRAM with a multiplexed address bus. A request is taken over a valid/ready handshake and carries an 18-bit word address, 16-bit write data, two byte enables and a write flag. The controller first presents the upper nine address bits as the row and drops the row strobe. It then presents the lower nine bits as the column and drops the column strobe of every enabled byte lane. It finishes with a precharge interval before it accepts another request.

Writes use the early-write form. Write enable goes low together with the row strobe, so it is settled before any column strobe falls, and the controller drives the data bus for the whole access while output enable stays high. Reads keep write enable high and pull output enable low only in the column phase. Read data is sampled in the last column cycle, and the result comes back with a one-cycle done pulse. Every phase length is derived from nanosecond parameters and the clock period.

Top module: `edo_lane_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high. The data bus is not driven, ready is high and done is low.
- R2: A request is accepted on a clock edge where valid and ready are both high. For the next RCD cycles the row strobe is low and the address pins carry request address bits [17:9].
- R3: The column phase follows the row phase. Throughout it the address pins carry request address bits [8:0] and hold them unchanged while any column strobe is low.
- R4: Column strobe bit 0 serves data bits [7:0] and goes low only if byte enable bit 0 is set. Column strobe bit 1 serves data bits [15:8] under byte enable bit 1. A request with both enables clear asserts neither strobe and leaves memory unchanged.
- R5: For a write, write enable is low and the data bus is driven for the whole row-low interval, starting before any column strobe falls. Output enable stays high.
- R6: For a read, write enable stays high, the data bus is not driven, and output enable is low only during the column phase.
- R7: Read data is captured on the last column cycle. Lanes whose enable is clear return zero. Done pulses for exactly one cycle, in the first precharge cycle, for reads and writes alike.
- R8: The column phase lasts the largest of the following: the column hold time, one cycle more than the column access time, enough cycles to meet the minimum row-low width, and enough cycles for read data to be sampled at least one cycle after the row access time.
- R9: After each access the row strobe stays high for at least the precharge cycle count before ready returns.
- R10: Each cycle count is the ceiling of its nanosecond parameter divided by CLK_NS, and never less than one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address; [17:9] row, [8:0] column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables; bit 0 lower byte, bit 1 upper byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes; bit 0 lower lane, bit 1 upper lane |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
Phase lengths are derived independently, the cycle is modelled from the request, and every strobe is compared on every clock. A phase counter that runs a cycle long or short therefore shows up as a strobe edge moving by one cycle, and it is caught on that same cycle. A wrong lane decode shows up as a column strobe on the wrong lane when the access starts. It also corrupts the behavioural memory in the bench, so the readback that follows the write returns the wrong byte. A capture made too early or a missing lane mask puts the bench's not-yet-valid or floating pattern into the returned data, and it is seen at the done pulse.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2,
    ST_PRE  = 2'd3
  } edo_state_e;

  // ceiling of ns / clk_ns, floor of one cycle
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // column phase: hold time, data sample after access, row-low width, row access
  function automatic int col_cycles(input int rcd, input int cac, input int cah,
                                    input int ras, input int rac);
    int c;
    c = max2(cah, cac + 1);
    c = max2(c, ras - rcd);
    c = max2(c, rac + 1 - rcd);
    return c;
  endfunction

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_ctrl_pkg::*;
#(
  parameter int RCD_C = 2,
  parameter int COL_C = 5,
  parameter int RP_C  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output edo_state_e state,
  output logic       accept,
  output logic       in_row,
  output logic       in_col,
  output logic       col_end
);
  localparam int MAXC = max2(max2(RCD_C, COL_C), RP_C);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_RCD = CW'(RCD_C - 1);
  localparam logic [CW-1:0] LD_COL = CW'(COL_C - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(RP_C - 1);

  logic          expired, load;
  logic [CW-1:0] load_val;
  edo_state_e    nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin nxt = ST_ROW;  load = 1'b1; load_val = LD_RCD; end
      ST_ROW:  if (expired)   begin nxt = ST_COL;  load = 1'b1; load_val = LD_COL; end
      ST_COL:  if (expired)   begin nxt = ST_PRE;  load = 1'b1; load_val = LD_RP;  end
      ST_PRE:  if (expired)   begin nxt = ST_IDLE; end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  edo_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  assign accept  = (state == ST_IDLE) && req_valid;
  assign in_row  = (state == ST_ROW);
  assign in_col  = (state == ST_COL);
  assign col_end = in_col && expired;
endmodule

// File: rtl/edo_lane_gate.sv
module edo_lane_gate #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    in_col,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES-1:0]        cas_n,
  output logic [LANES*LANE_W-1:0] rd_masked
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cas_n[i] = ~(in_col & be[i]);
    assign rd_masked[i*LANE_W +: LANE_W] = be[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
  import edo_ctrl_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int T_RCD_NS = 20,
  parameter int T_CAC_NS = 15,
  parameter int T_CAH_NS = 10,
  parameter int T_RAS_NS = 60,
  parameter int T_RAC_NS = 60,
  parameter int T_RP_NS  = 40,
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [LANES-1:0]      req_be,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W/2-1:0]   dram_addr,
  output logic                  dram_ras_n,
  output logic [LANES-1:0]      dram_cas_n,
  output logic                  dram_we_n,
  output logic                  dram_oe_n,
  output logic [DATA_W-1:0]     dram_dq_out,
  output logic                  dram_dq_oe,
  input  logic [DATA_W-1:0]     dram_dq_in
);
  localparam int PIN_W  = ADDR_W / 2;
  localparam int LANE_W = DATA_W / LANES;
  localparam int RCD_C  = ns2cyc(T_RCD_NS, CLK_NS);
  localparam int CAC_C  = ns2cyc(T_CAC_NS, CLK_NS);
  localparam int CAH_C  = ns2cyc(T_CAH_NS, CLK_NS);
  localparam int RAS_C  = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int RAC_C  = ns2cyc(T_RAC_NS, CLK_NS);
  localparam int RP_C   = ns2cyc(T_RP_NS, CLK_NS);
  localparam int COL_C  = col_cycles(RCD_C, CAC_C, CAH_C, RAS_C, RAC_C);

  edo_state_e state;
  logic accept, in_row, in_col, col_end, row_open;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_masked;
  logic [LANES-1:0]  be_q;
  logic              wr_q;

  edo_seq #(.RCD_C(RCD_C), .COL_C(COL_C), .RP_C(RP_C)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .state(state),
    .accept(accept), .in_row(in_row), .in_col(in_col), .col_end(col_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; wdata_q <= '0; be_q <= '0; wr_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr; wdata_q <= req_wdata; be_q <= req_be; wr_q <= req_write;
    end
  end

  edo_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .in_col(in_col), .be(be_q), .dq_in(dram_dq_in),
    .cas_n(dram_cas_n), .rd_masked(rd_masked)
  );

  assign row_open    = in_row | in_col;
  assign req_ready   = (state == ST_IDLE);
  assign dram_addr   = in_col ? addr_q[PIN_W-1:0] : addr_q[ADDR_W-1:PIN_W];
  assign dram_ras_n  = ~row_open;
  assign dram_we_n   = ~(row_open & wr_q);
  assign dram_oe_n   = ~(in_col & ~wr_q);
  assign dram_dq_oe  = row_open & wr_q;
  assign dram_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= col_end;
      if (col_end && !wr_q) rsp_rdata <= rd_masked;
    end
  end

  // ---------------- assertions ----------------
  logic        cas_on;
  logic [15:0] ras_hi_cnt, ras_lo_cnt;
  assign cas_on = ~&dram_cas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi_cnt <= 16'(RP_C);
      ras_lo_cnt <= '0;
    end else if (dram_ras_n) begin
      ras_lo_cnt <= '0;
      if (ras_hi_cnt != 16'hFFFF) ras_hi_cnt <= ras_hi_cnt + 16'd1;
    end else begin
      ras_hi_cnt <= '0;
      if (ras_lo_cnt != 16'hFFFF) ras_lo_cnt <= ras_lo_cnt + 16'd1;
    end
  end

  // R9
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && $past(dram_ras_n)) |-> (ras_hi_cnt >= 16'(RP_C)));
  // R9
  ready_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && ras_hi_cnt >= 16'(RP_C)));
  // R8
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && !$past(dram_ras_n)) |-> (ras_lo_cnt >= 16'(RAS_C)));
  // R4
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_on |-> !dram_ras_n);
  // R3
  col_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_on && $past(cas_on)) |-> $stable(dram_addr));
  // R5
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_on && !$past(cas_on) && !dram_we_n) |-> !$past(dram_we_n));
  // R5 R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_dq_oe && !dram_oe_n));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/edo_lane_ctrl_tb.sv
module edo_lane_ctrl_tb;
  localparam int CLK = 20;

  typedef struct packed {
    logic        ready, done, ras, lcas, ucas, we, oe, dqoe, chk_addr;
    logic [8:0]  addr;
    logic        chk_rd;
    logic [15:0] rd;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_done, dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] rsp_rdata, dram_dq_out;
  logic [15:0] dram_dq_in = 16'hEEEE;
  logic [8:0]  dram_addr;
  logic [1:0]  dram_cas_n;

  int checks = 0, errors = 0, cycles = 0;
  bit running = 1'b0;
  exp_t q[$];
  logic [15:0] shadow [int];
  logic [15:0] mem [int];

  always #(CLK/2) clk = ~clk;

  edo_lane_ctrl #(.CLK_NS(CLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  // whole cycles covering ns, at least one
  function automatic int cyc(input int ns);
    int n = 0;
    while (n * CLK < ns) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  int rcd_n, cac_n, cah_n, ras_n_c, rac_n, rp_n, col_n;
  initial begin
    rcd_n = cyc(20); cac_n = cyc(15); cah_n = cyc(10);
    ras_n_c = cyc(60); rac_n = cyc(60); rp_n = cyc(40);
    col_n = cah_n;
    if (cac_n + 1 > col_n)         col_n = cac_n + 1;
    if (ras_n_c - rcd_n > col_n)   col_n = ras_n_c - rcd_n;
    if (rac_n + 1 - rcd_n > col_n) col_n = rac_n + 1 - rcd_n;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic exp_t idle_vec();
    exp_t e = '0;
    e.ready = 1; e.ras = 1; e.lcas = 1; e.ucas = 1; e.we = 1; e.oe = 1;
    return e;
  endfunction

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (running) begin
      exp_t e;
      cycles++;
      e = (q.size() != 0) ? q.pop_front() : idle_vec();
      chk("R2 R9 ready",         {15'd0, req_ready},     {15'd0, e.ready});
      chk("R2 R8 R10 ras_n",     {15'd0, dram_ras_n},    {15'd0, e.ras});
      chk("R4 R3 cas_n",         {14'd0, dram_cas_n},    {14'd0, e.ucas, e.lcas});
      chk("R5 R6 we_n",          {15'd0, dram_we_n},     {15'd0, e.we});
      chk("R6 oe_n",             {15'd0, dram_oe_n},     {15'd0, e.oe});
      chk("R5 dq_oe",            {15'd0, dram_dq_oe},    {15'd0, e.dqoe});
      chk("R7 done",             {15'd0, rsp_done},      {15'd0, e.done});
      if (e.chk_addr) chk("R2 R3 addr", {7'd0, dram_addr}, {7'd0, e.addr});
      if (e.chk_rd)   chk("R7 rdata", rsp_rdata, e.rd);
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  // behavioural DRAM: rows/columns latched on strobe falls, early write, timed read data
  logic prev_ras = 1'b1;
  logic [1:0] prev_cas = 2'b11;
  logic [8:0] row_l = '0, col_l = '0;
  int ras_age = 0, cas_age = 0;
  always @(negedge clk) begin
    int k;
    if (!dram_ras_n && prev_ras) row_l = dram_addr;
    ras_age = dram_ras_n ? 0 : ras_age + 1;
    cas_age = (&dram_cas_n) ? 0 : cas_age + 1;
    for (int i = 0; i < 2; i++) begin
      if (!dram_cas_n[i] && prev_cas[i] && !dram_ras_n) begin
        col_l = dram_addr;
        k = {row_l, col_l};
        if (!dram_we_n) begin
          if (!mem.exists(k)) mem[k] = '0;
          mem[k][i*8 +: 8] = dram_dq_out[i*8 +: 8];
        end
      end
    end
    k = {row_l, col_l};
    for (int i = 0; i < 2; i++) begin
      if (!dram_ras_n && !dram_cas_n[i] && !dram_oe_n && dram_we_n)
        dram_dq_in[i*8 +: 8] = (cas_age >= cac_n && ras_age >= rac_n)
                               ? (mem.exists(k) ? mem[k][i*8 +: 8] : 8'h00) : 8'h5A;
      else
        dram_dq_in[i*8 +: 8] = 8'hEE;
    end
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
  end

  task automatic issue(input logic wr, input logic [1:0] be, input logic [17:0] a,
                       input logic [15:0] d);
    exp_t e;
    logic [15:0] er = '0;
    int k = a;
    @(posedge clk);
    while (q.size() != 0) @(posedge clk);
    #2;
    if (!shadow.exists(k)) shadow[k] = '0;
    for (int i = 0; i < 2; i++) begin
      if (be[i] && wr)  shadow[k][i*8 +: 8] = d[i*8 +: 8];
      if (be[i] && !wr) er[i*8 +: 8] = shadow[k][i*8 +: 8];
    end
    q.push_back(idle_vec());
    for (int i = 0; i < rcd_n; i++) begin
      e = '0; e.ras = 0; e.lcas = 1; e.ucas = 1; e.we = !wr; e.oe = 1; e.dqoe = wr;
      e.chk_addr = 1; e.addr = a[17:9];
      q.push_back(e);
    end
    for (int i = 0; i < col_n; i++) begin
      e = '0; e.ras = 0; e.lcas = !be[0]; e.ucas = !be[1]; e.we = !wr; e.oe = wr;
      e.dqoe = wr; e.chk_addr = 1; e.addr = a[8:0];
      q.push_back(e);
    end
    for (int i = 0; i < rp_n; i++) begin
      e = '0; e.ras = 1; e.lcas = 1; e.ucas = 1; e.we = 1; e.oe = 1;
      e.done = (i == 0); e.chk_rd = (i == 0) && !wr; e.rd = er;
      q.push_back(e);
    end
    req_write = wr; req_be = be; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ras_n", {15'd0, dram_ras_n}, 16'd1);
    chk("R1 cas_n", {14'd0, dram_cas_n}, 16'd3);
    chk("R1 we_n oe_n", {14'd0, dram_we_n, dram_oe_n}, 16'd3);
    chk("R1 dq_oe done", {14'd0, dram_dq_oe, rsp_done}, 16'd0);
    chk("R1 ready", {15'd0, req_ready}, 16'd1);
    running = 1'b1;
    // R5 R4 writes: full word, lower lane at top address, upper lane
    issue(1'b1, 2'b11, 18'h00000, 16'h1234);
    issue(1'b1, 2'b01, 18'h3FFFF, 16'hC3AB);
    issue(1'b1, 2'b10, 18'h2A155, 16'h9D77);
    // R4 no enables: memory must stay 1234
    issue(1'b1, 2'b00, 18'h00000, 16'hFFFF);
    issue(1'b1, 2'b11, 18'h1FF00, 16'hBEEF);
    // R4 lower lane overwrite of a full word
    issue(1'b1, 2'b01, 18'h1FF00, 16'h0042);
    // R6 R7 readbacks with each lane pattern
    issue(1'b0, 2'b11, 18'h00000, 16'h0000);
    issue(1'b0, 2'b01, 18'h3FFFF, 16'h0000);
    issue(1'b0, 2'b11, 18'h3FFFF, 16'h0000);
    issue(1'b0, 2'b10, 18'h2A155, 16'h0000);
    issue(1'b0, 2'b11, 18'h1FF00, 16'h0000);
    issue(1'b0, 2'b10, 18'h1FF00, 16'h0000);
    issue(1'b0, 2'b00, 18'h1FF00, 16'h0000);
    issue(1'b0, 2'b11, 18'h2A155, 16'h0000);
    @(posedge clk);
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule